// File: doc/BRIEF.md
# Frame Run Controller with Completion Pulse

This block decides when a two-output image processing engine starts a frame and when that frame is finished. Software writes an enable bit and a single-frame mode bit through a register-style strobe. When the enable is set and no frame is running, the controller issues a one-cycle start pulse. It then waits for the end-of-frame strobe of every output port and for the core to report idle. After that it raises a one-cycle completion pulse. This pulse is the last event of a frame, and after it a clean reset of the engine is safe.

In single-frame mode the enable clears itself at completion. In continuous mode the enable stays set, and the controller starts the next frame on the cycle after completion. The end-of-frame strobe of each port is held in its own sticky flag. A port whose enable input is low counts as finished. Clearing the enable while a frame is running does not abort the frame. The frame runs to completion and the controller then stays idle.

Top module: `frame_run_ctrl`

## Requirements
- R1: With the enable readback high and no frame running, `start_o` is high for exactly one cycle on the next clock edge. A write that sets the enable makes `enable_o` high at the edge after the write cycle, and `start_o` one edge later.
- R2: In single-frame mode (`cfg_single` = 1), `enable_o` falls at the same edge where `done_o` rises, unless a register write falls in the completion cycle.
- R3: A completion cycle is a cycle in which a frame is running, every enabled port has recorded its end-of-frame, and `core_idle` is high. `done_o` goes high at the edge that ends the completion cycle. If `core_idle` stays low, no completion happens.
- R4: `done_o` is never high in two consecutive cycles.
- R5: Each port's end-of-frame strobe is recorded on its own, in either order and with any gap between ports. All records clear at completion, so a strobe from an earlier frame never counts toward a later one.
- R6: In continuous mode (`cfg_single` = 0), `enable_o` stays high through completion, and `start_o` rises at the edge where `done_o` falls.
- R7: A port whose bit in `port_en` is low counts as having already sent its end-of-frame.
- R8: End-of-frame strobes that arrive while no frame is running are ignored and do not shorten the next frame.
- R9: Clearing the enable in the middle of a frame lets that frame complete with a `done_o` pulse, and no new `start_o` follows.
- R10: A register write in the completion cycle takes priority over the single-frame self-clear. The written enable value is kept.
- R11: Synchronous reset drives `enable_o`, `start_o` and `done_o` low and discards any running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe for the enable and mode bits |
| cfg_enable | input | 1 | Enable value to write |
| cfg_single | input | 1 | Mode value to write: 1 = single frame, 0 = continuous |
| port_en | input | NUM_PORTS | Per-port enable; a low bit means that port's end-of-frame is not awaited |
| port_eof | input | NUM_PORTS | Per-port end-of-frame strobe |
| core_idle | input | 1 | High when the processing core is idle |
| enable_o | output | 1 | Enable bit readback |
| start_o | output | 1 | One-cycle frame start pulse |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
Two events can land in the same cycle: the single-frame self-clear of the enable at completion, and a register write of the enable. The bench sets this up by first letting both end-of-frame flags settle with `core_idle` held low. It then raises `core_idle` and the write strobe on the same falling edge. The written value must survive, and a new start pulse must follow. A behavioural model compares `enable_o`, `start_o` and `done_o` on every cycle, so the bench also judges the exact edge of each pulse.

// File: rtl/frame_run_pkg.sv
package frame_run_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_t;
endpackage

// File: rtl/frame_eof_tracker.sv
module frame_eof_tracker #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 running,
  input  logic                 clear,
  input  logic [NUM_PORTS-1:0] port_en,
  input  logic [NUM_PORTS-1:0] port_eof,
  output logic                 all_seen
);
  logic [NUM_PORTS-1:0] seen_q;
  logic [NUM_PORTS-1:0] covered;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        seen_q[p] <= 1'b0;
      end else if (running && port_eof[p]) begin
        seen_q[p] <= 1'b1;
      end
    end
    assign covered[p] = seen_q[p] | ~port_en[p];

    // R8: a flag can only rise while a frame is running
    assert_flag_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(seen_q[p]) |-> $past(running));
  end

  assign all_seen = &covered;
endmodule

// File: rtl/frame_run_seq.sv
module frame_run_seq
  import frame_run_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_enable,
  input  logic cfg_single,
  input  logic all_seen,
  input  logic core_idle,
  output logic running,
  output logic complete,
  output logic enable_o,
  output logic start_o,
  output logic done_o
);
  run_state_t state_q;
  logic       single_q;

  assign running  = (state_q == RUN_BUSY);
  assign complete = running && all_seen && core_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_o <= 1'b0;
      single_q <= 1'b0;
    end else if (cfg_wr) begin
      enable_o <= cfg_enable;
      single_q <= cfg_single;
    end else if (complete && single_q) begin
      enable_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RUN_IDLE;
      start_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= complete;
      if (complete) begin
        state_q <= RUN_IDLE;
      end else if (!running && enable_o) begin
        state_q <= RUN_BUSY;
        start_o <= 1'b1;
      end
    end
  end

  assert_done_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_needs_idle_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(core_idle));
  assert_single_selfclear_R2: assert property (@(posedge clk) disable iff (rst)
    (complete && single_q && !cfg_wr) |=> (done_o && !enable_o));
  assert_continuous_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (complete && !single_q && enable_o && !cfg_wr) |=> (done_o && enable_o));
  assert_start_from_idle_R1: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ($past(enable_o) && !$past(running)));
endmodule

// File: rtl/frame_run_ctrl.sv
module frame_run_ctrl #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_enable,
  input  logic                 cfg_single,
  input  logic [NUM_PORTS-1:0] port_en,
  input  logic [NUM_PORTS-1:0] port_eof,
  input  logic                 core_idle,
  output logic                 enable_o,
  output logic                 start_o,
  output logic                 done_o
);
  logic running;
  logic complete;
  logic all_seen;

  frame_eof_tracker #(.NUM_PORTS(NUM_PORTS)) u_tracker (
    .clk      (clk),
    .rst      (rst),
    .running  (running),
    .clear    (complete),
    .port_en  (port_en),
    .port_eof (port_eof),
    .all_seen (all_seen)
  );

  frame_run_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_enable (cfg_enable),
    .cfg_single (cfg_single),
    .all_seen   (all_seen),
    .core_idle  (core_idle),
    .running    (running),
    .complete   (complete),
    .enable_o   (enable_o),
    .start_o    (start_o),
    .done_o     (done_o)
  );

  // R11: outputs are low in the cycle after reset
  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (!enable_o && !start_o && !done_o));
endmodule

// File: tb/frame_run_ctrl_bench.sv
`timescale 1ns/1ps
module frame_run_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_single = 1'b0;
  logic [1:0] port_en = 2'b11, port_eof = 2'b00;
  logic       core_idle = 1'b1;
  logic       enable_o, start_o, done_o;

  int checks = 0, errors = 0, cycles = 0;
  int done_cnt = 0, start_cnt = 0;

  // behavioural reference state
  bit m_en, m_single, m_busy, m_start, m_done;
  bit m_seen [2];

  always #2.5 clk = ~clk;

  frame_run_ctrl #(.NUM_PORTS(2)) u_frame_run_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_single(cfg_single), .port_en(port_en), .port_eof(port_eof),
    .core_idle(core_idle), .enable_o(enable_o), .start_o(start_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit fin;
    if (rst) begin
      m_en = 0; m_single = 0; m_busy = 0; m_start = 0; m_done = 0;
      m_seen[0] = 0; m_seen[1] = 0;
    end else begin
      fin = m_busy && (m_seen[0] || !port_en[0]) && (m_seen[1] || !port_en[1]) && core_idle;
      m_done = fin;
      m_start = 0;
      if (fin) begin
        m_busy = 0;
        m_seen[0] = 0; m_seen[1] = 0;
      end else begin
        if (m_busy) begin
          if (port_eof[0]) m_seen[0] = 1;
          if (port_eof[1]) m_seen[1] = 1;
        end else if (m_en) begin
          m_busy = 1;
          m_start = 1;
        end
      end
      if (cfg_wr) begin
        m_en = cfg_enable;
        m_single = cfg_single;
      end else if (fin && m_single) begin
        m_en = 0;
      end
    end
  end

  reg prev_done = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(enable_o == m_en, "R2 R6 R10 enable_o", enable_o, m_en);
      check(start_o == m_start, "R1 start_o", start_o, m_start);
      check(done_o == m_done, "R3 R5 R7 done_o", done_o, m_done);
      check(!(prev_done && done_o), "R4 done width", done_o, 0);
      if (done_o) done_cnt++;
      if (start_o) start_cnt++;
      prev_done = done_o;
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input bit en, input bit single);
    @(negedge clk);
    cfg_wr = 1; cfg_enable = en; cfg_single = single;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse_eof(input logic [1:0] which);
    @(negedge clk);
    port_eof = which;
    @(negedge clk);
    port_eof = 2'b00;
  endtask

  initial begin
    int d0, s0;
    wait_cyc(3);
    check(!enable_o && !start_o && !done_o, "R11 reset outputs",
          {enable_o, start_o, done_o}, 0);
    @(negedge clk); rst = 0;

    // R8: strobes with no frame running are ignored
    pulse_eof(2'b11);
    write_cfg(1, 1);
    wait_cyc(6);
    check(done_cnt == 0, "R8 stale eof ignored", done_cnt, 0);
    check(start_cnt == 1, "R1 single start", start_cnt, 1);

    // R5: ports in either order, separated
    pulse_eof(2'b10);
    wait_cyc(4);
    check(done_cnt == 0, "R5 one port only", done_cnt, 0);
    pulse_eof(2'b01);
    wait_cyc(3);
    check(done_cnt == 1, "R5 both ports done", done_cnt, 1);
    check(enable_o == 0, "R2 single selfclear", enable_o, 0);

    // R3: core not idle holds completion
    core_idle = 0;
    write_cfg(1, 1);
    wait_cyc(3);
    pulse_eof(2'b11);
    wait_cyc(5);
    check(done_cnt == 1, "R3 waits for idle", done_cnt, 1);
    core_idle = 1;
    wait_cyc(3);
    check(done_cnt == 2, "R3 done after idle", done_cnt, 2);

    // R7: disabled port counts as finished
    port_en = 2'b01;
    write_cfg(1, 1);
    wait_cyc(3);
    pulse_eof(2'b01);
    wait_cyc(3);
    check(done_cnt == 3, "R7 disabled port", done_cnt, 3);
    port_en = 2'b11;

    // R6: continuous mode runs back to back
    s0 = start_cnt;
    write_cfg(1, 0);
    for (int f = 0; f < 3; f++) begin
      wait_cyc(3);
      pulse_eof(2'b01);
      pulse_eof(2'b10);
    end
    wait_cyc(3);
    check(done_cnt == 6, "R6 three frames", done_cnt, 6);
    check(enable_o == 1, "R6 enable kept", enable_o, 1);
    check(start_cnt == s0 + 4, "R6 restarts", start_cnt, s0 + 4);

    // R9: clear enable mid frame
    write_cfg(0, 0);
    s0 = start_cnt;
    pulse_eof(2'b11);
    wait_cyc(6);
    check(done_cnt == 7, "R9 frame finishes", done_cnt, 7);
    check(start_cnt == s0, "R9 no restart", start_cnt, s0);

    // R10: write in the completion cycle beats self-clear
    core_idle = 0;
    write_cfg(1, 1);
    wait_cyc(3);
    pulse_eof(2'b11);
    wait_cyc(3);
    s0 = start_cnt; d0 = done_cnt;
    @(negedge clk);
    core_idle = 1; cfg_wr = 1; cfg_enable = 1; cfg_single = 0;
    @(negedge clk);
    cfg_wr = 0;
    wait_cyc(3);
    check(done_cnt == d0 + 1, "R10 completion", done_cnt, d0 + 1);
    check(enable_o == 1, "R10 write wins", enable_o, 1);
    check(start_cnt == s0 + 1, "R10 new start", start_cnt, s0 + 1);
    write_cfg(0, 0);
    pulse_eof(2'b11);
    wait_cyc(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule